// File: doc/BRIEF.md
# Residue-Checked Pipelined Execution Unit

This block is a single-issue execution unit that returns one of four kinds of result: a pass-through or constant, a sum or difference with carry handling, a shifted or rotated word, or a product that can also be added into a running accumulator. A modulo-3 check runs beside the datapath. The operands are reduced to their residues, and the operation is repeated in residue arithmetic to predict the residue of the result. The registered result is then reduced on its own, and the two residues are compared by XOR. A mismatch raises `error_o` a fixed number of cycles after the result appears.

The check is separable. The datapath runs as it would without protection, and the predictor only reads the operands and the carry that the datapath produced. A fault-mask input XORs a pattern into the result register, so a test can corrupt the result and watch the check respond. The operand width `W` must be even, because the prediction depends on 2^W ≡ 1 (mod 3). Results are 2W bits wide so that a full product fits.

Top module: `rc_exu`

## Requirements
- R1: `unit_i` 000 returns `a_i`, 001 returns `b_i`, 010 returns the constant 1, and 011 or 111 return 0. All are zero-extended to 2W bits, and `carry_o` is 0 for every `unit_i` with bit 2 clear.
- R2: `unit_i` 100 selects the adder. `sub_i` 00 gives a+b, 01 gives a+b+`carry_i`, 10 gives a-b, and 11 gives a-b-`carry_i`. The result is the low W bits. `carry_o` is the carry out for the add forms and the borrow for the subtract forms.
- R3: `unit_i` 101 selects the shifter. The amount is the low log2(W) bits of `b_i`. `sub_i` 00 is a logical left shift, 01 a logical right shift, 10 a rotate left and 11 a rotate right, all on a W-bit word. `carry_o` is 0.
- R4: `unit_i` 110 with `sub_i` 00 returns the unsigned 2W-bit product of a and b. With `sub_i` 01 it returns the two's-complement 2W-bit signed product. `carry_o` is 0.
- R5: `unit_i` 110 with `sub_i` 10 (unsigned) or 11 (signed) adds the product into a 2W-bit accumulator, returns the new value and gives its overflow on `carry_o`. When `acc_clr_i` is high, the accumulation starts from zero. On any other operation, `acc_clr_i` clears the accumulator.
- R6: `result_o` and `carry_o` show an operation one clock edge after its inputs are sampled.
- R7: `error_o` for an operation appears exactly two cycles after its result.
- R8: With a zero fault mask, no operation ever raises `error_o`.
- R9: A single set bit in `fault_mask_i` flips that bit of the registered result and raises `error_o` for any operation other than a logical shift.
- R10: For logical shifts (`unit_i` 101, `sub_i` 00 or 01) the check is inhibited, and `error_o` stays low even when the result is corrupted.
- R11: After reset, `result_o`, `carry_o` and `error_o` are 0 and the accumulator holds 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| a_i | input | W | Operand A |
| b_i | input | W | Operand B; low log2(W) bits give the shift amount |
| carry_i | input | 1 | Carry-in or borrow-in |
| unit_i | input | 3 | Functional unit select |
| sub_i | input | 2 | Sub-operation within the unit |
| acc_clr_i | input | 1 | Clear the accumulator |
| fault_mask_i | input | 2W | Test pattern XORed into the result register |
| result_o | output | 2W | Registered result |
| carry_o | output | 1 | Registered carry, borrow or accumulator overflow |
| error_o | output | 1 | Residue mismatch flag |

## Verification
Every result is due on the first edge after its inputs are driven. Its error flag is due two edges after that, so it is observed three cycles after the inputs. The bench drives a new operation on each falling edge and keeps its expectations in a three-deep pipeline. On each falling edge it compares the result of the previous operation and the error flag of the operation three steps back, so every value is sampled in the cycle where it is due and in no other. Neighbouring operations therefore keep their error flags low on both sides of a flagged one, which checks the latency in both directions.

// File: rtl/rc_exu_pkg.sv
package rc_exu_pkg;

  typedef enum logic [2:0] {
    U_PASS_A = 3'b000,
    U_PASS_B = 3'b001,
    U_ONE    = 3'b010,
    U_ZERO   = 3'b011,
    U_ADD    = 3'b100,
    U_SHIFT  = 3'b101,
    U_MUL    = 3'b110,
    U_RSVD   = 3'b111
  } unit_e;

  // residues are kept as 2-bit values 0..2
  function automatic logic [1:0] m3_add(input logic [1:0] x, input logic [1:0] y);
    logic [2:0] s;
    s = {1'b0, x} + {1'b0, y};
    return (s >= 3'd3) ? 2'(s - 3'd3) : s[1:0];
  endfunction

  function automatic logic [1:0] m3_neg(input logic [1:0] x);
    return (x == 2'd0) ? 2'd0 : 2'(2'd3 - x);
  endfunction

  function automatic logic [1:0] m3_sub(input logic [1:0] x, input logic [1:0] y);
    return m3_add(x, m3_neg(y));
  endfunction

  function automatic logic [1:0] m3_mul(input logic [1:0] x, input logic [1:0] y);
    logic [3:0] p;
    p = {2'b0, x} * {2'b0, y};
    return (p == 4'd4) ? 2'd1 : ((p >= 4'd3) ? 2'(p - 4'd3) : p[1:0]);
  endfunction

endpackage

// File: rtl/rc_exu_residue.sv
module rc_exu_residue #(
  parameter int IW = 16
) (
  input  logic [IW-1:0] vec_i,
  output logic [1:0]    res_o
);
  import rc_exu_pkg::*;

  localparam int NC = (IW + 1) / 2;
  localparam int PW = 2 * NC;

  logic [PW-1:0] pad;
  logic [1:0]    chain [0:NC];

  assign pad      = PW'(vec_i);
  assign chain[0] = 2'd0;

  // each 2-bit digit has weight 4^i, which is 1 mod 3
  for (genvar i = 0; i < NC; i++) begin : g_digit
    logic [1:0] dig;
    assign dig          = (pad[2*i +: 2] == 2'd3) ? 2'd0 : pad[2*i +: 2];
    assign chain[i + 1] = m3_add(chain[i], dig);
  end

  assign res_o = chain[NC];

endmodule

// File: rtl/rc_exu_datapath.sv
module rc_exu_datapath #(
  parameter int W = 16
) (
  input  logic           clk_i,
  input  logic           rst_ni,
  input  logic [W-1:0]   a_i,
  input  logic [W-1:0]   b_i,
  input  logic           carry_i,
  input  logic [2:0]     unit_i,
  input  logic [1:0]     sub_i,
  input  logic           acc_clr_i,
  input  logic [2*W-1:0] fault_mask_i,
  output logic           cout_d_o,
  output logic [2*W-1:0] res_q_o,
  output logic           cout_q_o
);
  import rc_exu_pkg::*;

  localparam int DW  = 2 * W;
  localparam int SHW = $clog2(W);

  unit_e                  unit;
  logic                   cin_eff;
  logic [W:0]             addsub;
  logic [SHW-1:0]         sh;
  logic [DW-1:0]          rol_t, ror_t;
  logic [W-1:0]           shift_r;
  logic [DW-1:0]          prod_u, prod;
  logic signed [DW-1:0]   sa_x, sb_x, prod_s;
  logic [DW-1:0]          acc_q, acc_eff;
  logic [DW:0]            acc_sum;
  logic                   macc;
  logic [DW-1:0]          res_d;
  logic                   cout_d;

  assign unit    = unit_e'(unit_i);
  assign cin_eff = sub_i[0] & carry_i;

  // adder: bit W is carry for add, borrow for subtract
  assign addsub = sub_i[1] ? ({1'b0, a_i} - {1'b0, b_i} - (W+1)'(cin_eff))
                           : ({1'b0, a_i} + {1'b0, b_i} + (W+1)'(cin_eff));

  assign sh    = b_i[SHW-1:0];
  assign rol_t = {a_i, a_i} << sh;
  assign ror_t = {a_i, a_i} >> sh;

  always_comb begin
    unique case (sub_i)
      2'b00:   shift_r = a_i << sh;
      2'b01:   shift_r = a_i >> sh;
      2'b10:   shift_r = rol_t[DW-1:W];
      default: shift_r = ror_t[W-1:0];
    endcase
  end

  assign sa_x    = signed'({{W{a_i[W-1]}}, a_i});
  assign sb_x    = signed'({{W{b_i[W-1]}}, b_i});
  assign prod_s  = sa_x * sb_x;
  assign prod_u  = {{W{1'b0}}, a_i} * {{W{1'b0}}, b_i};
  assign prod    = sub_i[0] ? DW'(prod_s) : prod_u;

  assign macc    = (unit == U_MUL) && sub_i[1];
  assign acc_eff = acc_clr_i ? '0 : acc_q;
  assign acc_sum = {1'b0, acc_eff} + {1'b0, prod};

  always_comb begin
    res_d  = '0;
    cout_d = 1'b0;
    unique case (unit)
      U_PASS_A: res_d = DW'(a_i);
      U_PASS_B: res_d = DW'(b_i);
      U_ONE:    res_d = DW'(1);
      U_ADD: begin
        res_d  = DW'(addsub[W-1:0]);
        cout_d = addsub[W];
      end
      U_SHIFT:  res_d = DW'(shift_r);
      U_MUL: begin
        if (macc) begin
          res_d  = acc_sum[DW-1:0];
          cout_d = acc_sum[DW];
        end else begin
          res_d  = prod;
        end
      end
      default:  res_d = '0;
    endcase
  end

  assign cout_d_o = cout_d;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      res_q_o  <= '0;
      cout_q_o <= 1'b0;
      acc_q    <= '0;
    end else begin
      res_q_o  <= res_d ^ fault_mask_i;
      cout_q_o <= cout_d;
      if (macc)           acc_q <= acc_sum[DW-1:0];
      else if (acc_clr_i) acc_q <= '0;
    end
  end

  p_pass_a_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (unit_i == 3'b000 && fault_mask_i == '0)
      |=> (res_q_o[W-1:0] == $past(a_i) && res_q_o[DW-1:W] == '0));

  p_carry_zero_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (unit_i[2] == 1'b0) |=> (cout_q_o == 1'b0));

  p_acc_clear_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (acc_clr_i && unit_i != 3'b110) |=> (acc_q == '0));

endmodule

// File: rtl/rc_exu_predict.sv
module rc_exu_predict #(
  parameter int W = 16
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] a_i,
  input  logic [W-1:0] b_i,
  input  logic         carry_i,
  input  logic [2:0]   unit_i,
  input  logic [1:0]   sub_i,
  input  logic         acc_clr_i,
  input  logic         cout_d_i,
  output logic [1:0]   pred_q_o,
  output logic         en_q_o
);
  import rc_exu_pkg::*;

  unit_e      unit;
  logic [1:0] ra, rb, sra, srb, rp, acc_res_q, acc_eff, pred_d;
  logic       cin_eff, neg, macc, en_d;

  rc_exu_residue #(.IW(W)) u_res_a (.vec_i(a_i), .res_o(ra));
  rc_exu_residue #(.IW(W)) u_res_b (.vec_i(b_i), .res_o(rb));

  assign unit    = unit_e'(unit_i);
  assign cin_eff = sub_i[0] & carry_i;
  assign macc    = (unit == U_MUL) && sub_i[1];

  // signed value = unsigned pattern - sign (2^W == 1 mod 3)
  assign sra = m3_sub(ra, {1'b0, a_i[W-1]});
  assign srb = m3_sub(rb, {1'b0, b_i[W-1]});
  // negative product stored as p + 2^(2W), adds 1
  assign neg = (a_i[W-1] ^ b_i[W-1]) && (a_i != '0) && (b_i != '0);
  assign rp  = sub_i[0] ? m3_add(m3_mul(sra, srb), {1'b0, neg}) : m3_mul(ra, rb);

  assign acc_eff = acc_clr_i ? 2'd0 : acc_res_q;
  assign en_d    = !((unit == U_SHIFT) && !sub_i[1]);

  always_comb begin
    unique case (unit)
      U_PASS_A: pred_d = ra;
      U_PASS_B: pred_d = rb;
      U_ONE:    pred_d = 2'd1;
      U_ADD:    pred_d = sub_i[1]
                  ? m3_add(m3_sub(m3_sub(ra, rb), {1'b0, cin_eff}), {1'b0, cout_d_i})
                  : m3_sub(m3_add(m3_add(ra, rb), {1'b0, cin_eff}), {1'b0, cout_d_i});
      U_SHIFT:  pred_d = b_i[0] ? m3_neg(ra) : ra;
      U_MUL:    pred_d = macc ? m3_sub(m3_add(acc_eff, rp), {1'b0, cout_d_i}) : rp;
      default:  pred_d = 2'd0;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pred_q_o  <= 2'd0;
      en_q_o    <= 1'b0;
      acc_res_q <= 2'd0;
    end else begin
      pred_q_o <= pred_d;
      en_q_o   <= en_d;
      if (macc)           acc_res_q <= pred_d;
      else if (acc_clr_i) acc_res_q <= 2'd0;
    end
  end

  p_res_range_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (acc_res_q != 2'd3) && (pred_q_o != 2'd3));

endmodule

// File: rtl/rc_exu_check.sv
module rc_exu_check #(
  parameter int W = 16
) (
  input  logic           clk_i,
  input  logic           rst_ni,
  input  logic [2*W-1:0] res_q_i,
  input  logic [1:0]     pred_q_i,
  input  logic           en_q_i,
  output logic           err_q_o
);
  logic [1:0] act_d, act_q, pred_qq;
  logic       en_qq;

  rc_exu_residue #(.IW(2*W)) u_res_out (.vec_i(res_q_i), .res_o(act_d));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      act_q   <= 2'd0;
      pred_qq <= 2'd0;
      en_qq   <= 1'b0;
      err_q_o <= 1'b0;
    end else begin
      act_q   <= act_d;
      pred_qq <= pred_q_i;
      en_qq   <= en_q_i;
      err_q_o <= en_qq & (|(act_q ^ pred_qq));
    end
  end

  p_err_gated_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en_qq |=> !err_q_o);

endmodule

// File: rtl/rc_exu.sv
module rc_exu #(
  parameter int W = 16
) (
  input  logic           clk_i,
  input  logic           rst_ni,
  input  logic [W-1:0]   a_i,
  input  logic [W-1:0]   b_i,
  input  logic           carry_i,
  input  logic [2:0]     unit_i,
  input  logic [1:0]     sub_i,
  input  logic           acc_clr_i,
  input  logic [2*W-1:0] fault_mask_i,
  output logic [2*W-1:0] result_o,
  output logic           carry_o,
  output logic           error_o
);
  logic       cout_d;
  logic [1:0] pred_q;
  logic       en_q;

  rc_exu_datapath #(.W(W)) u_dp (
    .clk_i, .rst_ni, .a_i, .b_i, .carry_i, .unit_i, .sub_i, .acc_clr_i,
    .fault_mask_i, .cout_d_o(cout_d), .res_q_o(result_o), .cout_q_o(carry_o)
  );

  rc_exu_predict #(.W(W)) u_pred (
    .clk_i, .rst_ni, .a_i, .b_i, .carry_i, .unit_i, .sub_i, .acc_clr_i,
    .cout_d_i(cout_d), .pred_q_o(pred_q), .en_q_o(en_q)
  );

  rc_exu_check #(.W(W)) u_chk (
    .clk_i, .rst_ni, .res_q_i(result_o), .pred_q_i(pred_q), .en_q_i(en_q),
    .err_q_o(error_o)
  );

  p_clean_quiet_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (fault_mask_i == '0) |-> ##3 !error_o);

  p_flip_detect_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($countones(fault_mask_i) == 1 && !(unit_i == 3'b101 && !sub_i[1]))
      |-> ##3 error_o);

  p_shift_inhibit_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (unit_i == 3'b101 && !sub_i[1]) |-> ##3 !error_o);

endmodule

// File: tb/rc_exu_test.sv
module rc_exu_test;
  localparam int W  = 4;
  localparam int DW = 2 * W;
  localparam int WM = (1 << W) - 1;
  localparam int DM = (1 << DW) - 1;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [W-1:0]  a = '0, b = '0;
  logic          ci = 1'b0, clr = 1'b0;
  logic [2:0]    unit = '0;
  logic [1:0]    sub = '0;
  logic [DW-1:0] fm = '0;
  logic [DW-1:0] result;
  logic          carry, error;

  int checks = 0, errors = 0;
  int m_acc = 0;
  bit r_v = 0; int r_res = 0; int r_co = 0; string r_tag = "";
  bit e_v [1:3] = '{0, 0, 0};
  int e_x [1:3] = '{0, 0, 0};
  string e_t [1:3] = '{"", "", ""};

  rc_exu #(.W(W)) uut (
    .clk_i(clk), .rst_ni(rst_n), .a_i(a), .b_i(b), .carry_i(ci), .unit_i(unit),
    .sub_i(sub), .acc_clr_i(clr), .fault_mask_i(fm), .result_o(result),
    .carry_o(carry), .error_o(error)
  );

  always #2 clk = ~clk;

  initial begin
    #800000;
    errors++;
    $display("FAIL watchdog expired");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual %0d expected %0d", tag, act, exp);
    end
  endtask

  function automatic int sx(input int v);
    return (v >= (1 << (W - 1))) ? v - (1 << W) : v;
  endfunction

  task automatic step(input int u, input int s, input int av, input int bv,
                      input int cv, input int cl, input int fmv, input string tag);
    int res, co, k, p, acc;
    bit ex_err;
    res = 0; co = 0;
    k = bv & (W - 1);
    case (u)
      0: res = av;
      1: res = bv;
      2: res = 1;
      4: begin
        case (s)
          0: begin res = av + bv;      co = res >> W; end
          1: begin res = av + bv + cv; co = res >> W; end
          2: begin res = av - bv;      co = (res < 0); end
          default: begin res = av - bv - cv; co = (res < 0); end
        endcase
        res = res & WM;
      end
      5: begin
        case (s)
          0: res = (av << k) & WM;
          1: res = av >> k;
          2: res = ((av << k) | (av >> (W - k))) & WM;
          default: res = ((av >> k) | (av << (W - k))) & WM;
        endcase
      end
      6: begin
        p = s[0] ? sx(av) * sx(bv) : av * bv;
        p = p & DM;
        if (s[1]) begin
          acc = (cl ? 0 : m_acc) + p;
          res = acc & DM; co = acc >> DW; m_acc = res;
        end else res = p;
      end
      default: res = 0;
    endcase
    if (!(u == 6 && s[1]) && cl) m_acc = 0;
    ex_err = (fmv != 0) && !(u == 5 && s < 2);
    res = res ^ fmv;

    @(negedge clk);
    if (r_v) begin
      chk({r_tag, " result"}, int'(result), r_res);
      chk({r_tag, " carry"}, int'(carry), r_co);
    end
    if (e_v[3]) chk({e_t[3], " error"}, int'(error), e_x[3]);
    e_v[3] = e_v[2]; e_x[3] = e_x[2]; e_t[3] = e_t[2];
    e_v[2] = e_v[1]; e_x[2] = e_x[1]; e_t[2] = e_t[1];
    e_v[1] = 1'b1;   e_x[1] = int'(ex_err); e_t[1] = tag;
    r_v = 1'b1; r_res = res; r_co = co; r_tag = tag;
    unit = 3'(u); sub = 2'(s); a = W'(av); b = W'(bv);
    ci = cv[0]; clr = cl[0]; fm = DW'(fmv);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    // R11: reset state
    chk("R11 result", int'(result), 0);
    chk("R11 carry", int'(carry), 0);
    chk("R11 error", int'(error), 0);
    rst_n = 1'b1;
    // R11: accumulator starts at zero
    step(6, 2, 3, 5, 0, 0, 0, "R11");

    // R1: pass and constants
    for (int u = 0; u < 8; u++)
      if (u < 4 || u == 7)
        for (int x = 0; x < 16; x++)
          for (int y = 0; y < 16; y++) step(u, 0, x, y, 0, 0, 0, "R1");

    // R2: adder, every sub-op, operand pair and carry-in
    for (int s = 0; s < 4; s++)
      for (int x = 0; x < 16; x++)
        for (int y = 0; y < 16; y++)
          for (int c = 0; c < 2; c++) step(4, s, x, y, c, 0, 0, "R2");

    // R3: shifter, every amount
    for (int s = 0; s < 4; s++)
      for (int x = 0; x < 16; x++)
        for (int y = 0; y < 16; y++) step(5, s, x, y, 0, 0, 0, "R3");

    // R4: plain multiply
    for (int s = 0; s < 2; s++)
      for (int x = 0; x < 16; x++)
        for (int y = 0; y < 16; y++) step(6, s, x, y, 0, 0, 0, "R4");

    // R5: accumulate with periodic clear, overflow on carry
    for (int s = 2; s < 4; s++)
      for (int x = 0; x < 16; x++)
        for (int y = 0; y < 16; y++)
          step(6, s, x, y, 0, ((x + y) % 7 == 0) ? 1 : 0, 0, "R5");
    step(6, 2, 15, 15, 0, 0, 0, "R5");
    step(0, 0, 1, 2, 0, 1, 0, "R5");
    step(6, 2, 3, 5, 0, 0, 0, "R5");
    step(6, 3, 15, 2, 0, 0, 0, "R5");

    // R8: mixed clean sequence, error must stay low
    for (int i = 0; i < 400; i++)
      step((i * 7) % 8, (i * 3) % 4, (i * 5) % 16, (i * 11) % 16, i % 2, (i % 13 == 0) ? 1 : 0, 0, "R8");

    // R9 / R10: every single-bit flip on every unit and sub-op
    for (int u = 0; u < 8; u++)
      for (int s = 0; s < 4; s++)
        for (int bit_i = 0; bit_i < DW; bit_i++)
          step(u, s, (bit_i * 5 + u) % 16, (bit_i * 3 + s + 1) % 16, bit_i % 2, 0,
               1 << bit_i, (u == 5 && s < 2) ? "R10" : "R9");

    // R6 / R7: isolated fault between clean ops pins result and error timing
    step(4, 0, 2, 3, 0, 0, 0, "R7");
    step(4, 0, 6, 7, 0, 0, 4, "R7");
    step(4, 0, 1, 1, 0, 0, 0, "R6");
    step(4, 0, 9, 9, 0, 0, 0, "R7");
    step(0, 0, 0, 0, 0, 0, 0, "R7");

    repeat (4) step(0, 0, 0, 0, 0, 0, 0, "R8");

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule